// File: doc/BRIEF.md
# Ping-Pong Receive DMA Buffer Controller

This block writes received frame bytes into one of two receive buffers in external memory. The host sets up each buffer with a start address, a byte limit and a status byte. It hands a buffer to the controller by setting that buffer's ownership bit. A next-buffer flag tells the host which buffer the next frame will use. The first byte of a frame claims that buffer, raises a busy flag and flips the next-buffer flag to the other buffer.

Bytes arrive on a valid/ready stream that carries a last marker and a CRC-good flag. Each byte goes out through a one-deep byte write master at the current-address pointer, which then moves up by one. When the frame ends, the controller gives the buffer back to the host. It clears the ownership bit, records done, CRC-error and truncation flags in the buffer's status byte, and stores the written length. If the next buffer is not owned, the whole frame is dropped and an overrun flag is set. The host may also ask for a gap, which skips bytes in the active buffer. A gap that reaches the end of the buffer closes it and carries the rest of the skip into the other buffer.

Top module: `rxpp_dma_rx`

## Requirements
- R1: After reset both status bytes are 0x00, next_buf is 0 (buffer A), rx_busy is 0, cur_addr is 0, mem_valid is 0 and in_ready is 1.
- R2: A host write with cfg_fld 0, 1 or 2 loads the start address, the byte limit (low 16 bits) or the status byte of the buffer chosen by cfg_buf (0 = A, 1 = B). The status byte then appears on status_a or status_b. Status bit 7 means the controller owns the buffer.
- R3: When the first byte of a frame is accepted and the buffer named by next_buf has bit 7 set, rx_busy becomes 1, next_buf toggles, and the byte is written at that buffer's start address.
- R4: Each later byte of the frame is written at the next consecutive address. cur_addr always holds the address one past the last byte written.
- R5: If the buffer named by next_buf does not have bit 7 set when a frame's first byte arrives, no byte of that frame is written. Status bit 3 (overrun) of that buffer is set, rx_busy stays 0 and next_buf is unchanged.
- R6: When the byte marked last is accepted, the buffer's status clears bit 7, sets bit 0 (done) and sets bit 1 exactly when in_crc_ok was 0. rx_busy returns to 0 and frame_len holds the number of bytes written to that buffer.
- R7: Bytes beyond a buffer's limit are not written. At the end of such a frame status bit 2 (truncated) is set and frame_len equals the limit.
- R8: While mem_valid is 1 and mem_ready is 0, mem_addr and mem_data hold steady. in_ready is 0 whenever mem_valid or gap_valid is 1.
- R9: A gap request during a frame that is smaller than the space left in the active buffer adds gap_len to cur_addr.
- R10: A gap request that is at least the space left closes the active buffer (bit 7 cleared, bit 0 set) and makes the other buffer active. cur_addr becomes the other buffer's start plus the part of the gap that did not fit, and next_buf toggles.
- R11: A frame whose length equals the buffer limit completes with bit 2 clear and frame_len equal to the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Host register write strobe |
| cfg_buf | input | 1 | Buffer select, 0 = A, 1 = B |
| cfg_fld | input | 2 | 0 start address, 1 byte limit, 2 status |
| cfg_wdata | input | 32 | Host write data |
| gap_valid | input | 1 | Gap request pulse |
| gap_len | input | 16 | Number of bytes to skip |
| in_valid | input | 1 | Received byte valid |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_crc_ok | input | 1 | Frame CRC good, read with the last byte |
| in_ready | output | 1 | Byte accepted this cycle when high with in_valid |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory write byte address |
| mem_data | output | 8 | Memory write byte |
| mem_ready | input | 1 | Memory accepts the pending write |
| next_buf | output | 1 | Buffer the next frame will use |
| rx_busy | output | 1 | A frame is being written |
| cur_addr | output | 32 | Current buffer address pointer |
| frame_len | output | 16 | Length written for the last completed frame |
| status_a | output | 8 | Status byte of buffer A |
| status_b | output | 8 | Status byte of buffer B |

## Verification
The hardest case to reach is the gap that runs past the end of the active buffer. To get there, a frame has to be in progress with a known count, and the gap must arrive between bytes while the memory port is stalling at random. The bench first opens a frame and writes a few bytes. It then sends a small gap that fits and one more byte, and then a gap larger than the space left. It checks that the first buffer is closed and that the pointer moves into the second buffer at the carried-over offset. The scoreboard confirms that the next byte lands there.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
  localparam int STW      = 8;
  localparam int ST_DONE  = 0;
  localparam int ST_CRCE  = 1;
  localparam int ST_TRUNC = 2;
  localparam int ST_OVR   = 3;
  localparam int ST_OWN   = 7;

  typedef enum logic [1:0] {FLD_START = 2'd0, FLD_LIMIT = 2'd1, FLD_STATUS = 2'd2} fld_e;
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_FILL = 2'd1, S_DROP = 2'd2} eng_e;

  // gap fits when strictly smaller than the room left
  function automatic logic gap_fits(input logic [31:0] room, input logic [31:0] gap);
    return gap < room;
  endfunction

  function automatic logic [31:0] gap_rest(input logic [31:0] room, input logic [31:0] gap);
    return gap - room;
  endfunction

  function automatic logic [STW-1:0] close_status(input logic [STW-1:0] s,
                                                  input logic crc_bad, input logic trunc);
    logic [STW-1:0] r;
    r = s;
    r[ST_OWN]   = 1'b0;
    r[ST_DONE]  = 1'b1;
    r[ST_CRCE]  = crc_bad;
    r[ST_TRUNC] = trunc;
    return r;
  endfunction
endpackage

// File: rtl/rxpp_bufregs.sv
module rxpp_bufregs
  import rxpp_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_buf,
  input  logic [1:0]          cfg_fld,
  input  logic [AW-1:0]       cfg_wdata,
  input  logic [1:0]          upd_en,
  input  logic [1:0][STW-1:0] upd_val,
  output logic [1:0][AW-1:0]  start_q,
  output logic [1:0][CW-1:0]  limit_q,
  output logic [1:0][STW-1:0] status_q
);
  for (genvar i = 0; i < 2; i++) begin : g_buf
    logic host_hit;
    assign host_hit = cfg_we && (cfg_buf == 1'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        start_q[i]  <= '0;
        limit_q[i]  <= '0;
        status_q[i] <= '0;
      end else begin
        if (host_hit && cfg_fld == FLD_START) start_q[i] <= cfg_wdata;
        if (host_hit && cfg_fld == FLD_LIMIT) limit_q[i] <= cfg_wdata[CW-1:0];
        // controller updates win over a host write in the same cycle
        if (upd_en[i]) status_q[i] <= upd_val[i];
        else if (host_hit && cfg_fld == FLD_STATUS) status_q[i] <= cfg_wdata[STW-1:0];
      end
    end

    // R2: host status write lands when no controller update competes
    a_r2_host_status: assert property (@(posedge clk) disable iff (!rst_n)
      (host_hit && cfg_fld == FLD_STATUS && !upd_en[i]) |=> status_q[i] == $past(cfg_wdata[STW-1:0]));
  end
endmodule

// File: rtl/rxpp_memwr.sv
module rxpp_memwr #(
  parameter int AW = 32,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  output logic          mem_busy,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  input  logic          mem_ready
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else if (push) begin
      mem_valid <= 1'b1;
      mem_addr  <= push_addr;
      mem_data  <= push_data;
    end else if (mem_ready) begin
      mem_valid <= 1'b0;
    end
  end

  assign mem_busy = mem_valid;

  // R8: stalled request holds its address and data
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));
  // R8: no new byte is pushed over a pending one
  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !mem_valid);
endmodule

// File: rtl/rxpp_ctrl.sv
module rxpp_ctrl
  import rxpp_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_last,
  input  logic                in_crc_ok,
  output logic                in_ready,
  input  logic                gap_valid,
  input  logic [CW-1:0]       gap_len,
  input  logic                mem_busy,
  input  logic [1:0][AW-1:0]  start_q,
  input  logic [1:0][CW-1:0]  limit_q,
  input  logic [1:0][STW-1:0] status_q,
  output logic                push,
  output logic [AW-1:0]       push_addr,
  output logic [1:0]          upd_en,
  output logic [1:0][STW-1:0] upd_val,
  output logic                next_buf,
  output logic                rx_busy,
  output logic [AW-1:0]       cur_addr,
  output logic [CW-1:0]       frame_len
);
  eng_e          st, n_st;
  logic          act, n_act, nxt, n_nxt, trn, n_trn;
  logic [CW-1:0] cnt, n_cnt, len, n_len;
  logic [AW-1:0] cur, n_cur;

  // named events for the assertions
  logic          acc, idle, own_nxt, frame_start, frame_refused, take_byte, frame_end, gap_take;
  logic          f_act, has_room, fits, other, own_other;
  logic [CW-1:0] f_cnt, room, rest;
  logic [AW-1:0] f_addr;

  assign in_ready      = !mem_busy && !gap_valid;
  assign acc           = in_valid && in_ready;
  assign idle          = (st == S_IDLE);
  assign own_nxt       = status_q[nxt][ST_OWN];
  assign frame_start   = acc && idle && own_nxt;
  assign frame_refused = acc && idle && !own_nxt;
  assign take_byte     = frame_start || (acc && st == S_FILL);
  assign frame_end     = take_byte && in_last;
  assign gap_take      = gap_valid && st == S_FILL;

  assign f_act    = idle ? nxt : act;
  assign f_cnt    = idle ? '0 : cnt;
  assign f_addr   = idle ? start_q[nxt] : cur;
  assign has_room = f_cnt < limit_q[f_act];

  assign room      = (cnt >= limit_q[act]) ? '0 : limit_q[act] - cnt;
  assign fits      = gap_fits(32'(room), 32'(gap_len));
  assign rest      = CW'(gap_rest(32'(room), 32'(gap_len)));
  assign other     = ~act;
  assign own_other = status_q[other][ST_OWN];

  always_comb begin
    n_st = st; n_act = act; n_nxt = nxt; n_trn = trn;
    n_cnt = cnt; n_cur = cur; n_len = len;
    push = 1'b0;
    push_addr = f_addr;
    upd_en = '0;
    upd_val = status_q;
    if (take_byte) begin
      n_act = f_act;
      n_cnt = f_cnt;
      n_cur = f_addr;
      n_trn = idle ? 1'b0 : trn;
      if (frame_start) n_nxt = ~nxt;
      if (has_room) begin
        push  = 1'b1;
        n_cnt = f_cnt + 1'b1;
        n_cur = f_addr + 1'b1;
      end else begin
        n_trn = 1'b1;
      end
      if (in_last) begin
        upd_en[f_act]  = 1'b1;
        upd_val[f_act] = close_status(status_q[f_act], !in_crc_ok, n_trn);
        n_len = n_cnt;
        n_st  = S_IDLE;
      end else begin
        n_st = S_FILL;
      end
    end else if (frame_refused) begin
      upd_en[nxt]          = 1'b1;
      upd_val[nxt][ST_OVR] = 1'b1;
      n_st = in_last ? S_IDLE : S_DROP;
    end else if (st == S_DROP && acc && in_last) begin
      n_st = S_IDLE;
    end else if (gap_take) begin
      if (fits) begin
        n_cur = cur + AW'(gap_len);
        n_cnt = cnt + gap_len;
      end else begin
        upd_en[act]  = 1'b1;
        upd_val[act] = close_status(status_q[act], 1'b0, trn);
        n_act = other;
        n_nxt = ~nxt;
        n_trn = 1'b0;
        if (own_other) begin
          n_cur = start_q[other] + AW'(rest);
          n_cnt = rest;
        end else begin
          upd_en[other]          = 1'b1;
          upd_val[other][ST_OVR] = 1'b1;
          n_st = S_DROP;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      act <= 1'b0;
      nxt <= 1'b0;
      trn <= 1'b0;
      cnt <= '0;
      cur <= '0;
      len <= '0;
    end else begin
      st  <= n_st;
      act <= n_act;
      nxt <= n_nxt;
      trn <= n_trn;
      cnt <= n_cnt;
      cur <= n_cur;
      len <= n_len;
    end
  end

  assign next_buf  = nxt;
  assign rx_busy   = (st == S_FILL);
  assign cur_addr  = cur;
  assign frame_len = len;

  // R5: a frame only opens on a buffer the controller owns
  a_r5_owned_only: assert property (@(posedge clk) disable iff (!rst_n)
    (push && idle) |-> status_q[nxt][ST_OWN]);
  // R7: never write past the limit of the active buffer
  a_r7_room: assert property (@(posedge clk) disable iff (!rst_n)
    (push && st == S_FILL) |-> cnt < limit_q[act]);
  // R3: busy rising from idle comes with a flipped next-buffer flag
  a_r3_flip: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (rx_busy || $past(in_last)) && next_buf != $past(next_buf));
  // R6: a completed frame releases its buffer and drops busy
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !rx_busy && !status_q[$past(f_act)][ST_OWN]);
  // R8: input is stalled while a write is pending
  a_r8_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    mem_busy |-> !in_ready);
endmodule

// File: rtl/rxpp_dma_rx.sv
module rxpp_dma_rx
  import rxpp_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_buf,
  input  logic [1:0]    cfg_fld,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          gap_valid,
  input  logic [CW-1:0] gap_len,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  input  logic          in_crc_ok,
  output logic          in_ready,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  input  logic          mem_ready,
  output logic          next_buf,
  output logic          rx_busy,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] frame_len,
  output logic [STW-1:0] status_a,
  output logic [STW-1:0] status_b
);
  logic [1:0][AW-1:0]  start_q;
  logic [1:0][CW-1:0]  limit_q;
  logic [1:0][STW-1:0] status_q;
  logic [1:0]          upd_en;
  logic [1:0][STW-1:0] upd_val;
  logic                push, mem_busy;
  logic [AW-1:0]       push_addr;

  rxpp_bufregs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_buf(cfg_buf), .cfg_fld(cfg_fld),
    .cfg_wdata(cfg_wdata), .upd_en(upd_en), .upd_val(upd_val),
    .start_q(start_q), .limit_q(limit_q), .status_q(status_q)
  );

  rxpp_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last), .in_crc_ok(in_crc_ok),
    .in_ready(in_ready), .gap_valid(gap_valid), .gap_len(gap_len), .mem_busy(mem_busy),
    .start_q(start_q), .limit_q(limit_q), .status_q(status_q), .push(push),
    .push_addr(push_addr), .upd_en(upd_en), .upd_val(upd_val), .next_buf(next_buf),
    .rx_busy(rx_busy), .cur_addr(cur_addr), .frame_len(frame_len)
  );

  rxpp_memwr #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .push(push), .push_addr(push_addr), .push_data(in_data),
    .mem_busy(mem_busy), .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_ready(mem_ready)
  );

  assign status_a = status_q[0];
  assign status_b = status_q[1];
endmodule

// File: tb/rxpp_dma_rx_tb.sv
module rxpp_dma_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_buf = 1'b0;
  logic [1:0]  cfg_fld = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        gap_valid = 1'b0;
  logic [15:0] gap_len = '0;
  logic        in_valid = 1'b0, in_last = 1'b0, in_crc_ok = 1'b1;
  logic [7:0]  in_data = '0;
  logic        in_ready, mem_valid, mem_ready = 1'b0;
  logic [31:0] mem_addr, cur_addr;
  logic [7:0]  mem_data, status_a, status_b;
  logic        next_buf, rx_busy;
  logic [15:0] frame_len;

  int checks = 0, errors = 0, writes = 0, cycles = 0;
  logic [39:0] expq[$];
  logic [7:0]  lfsr = 8'hA5;
  logic        done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rxpp_dma_rx u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_buf(cfg_buf), .cfg_fld(cfg_fld),
    .cfg_wdata(cfg_wdata), .gap_valid(gap_valid), .gap_len(gap_len), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_crc_ok(in_crc_ok), .in_ready(in_ready),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready),
    .next_buf(next_buf), .rx_busy(rx_busy), .cur_addr(cur_addr), .frame_len(frame_len),
    .status_a(status_a), .status_b(status_b)
  );

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: memory side; decide ready at negedge, handshake completes at next posedge
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (rst_n && !done) begin
      mem_ready = lfsr[0] | lfsr[3];
      if (mem_valid) chk("R8 in_ready low while write pending", 40'(in_ready), 40'(0));
      if (mem_valid && mem_ready) begin
        writes++;
        if (expq.size() == 0) chk("R5/R7 unexpected memory write", {mem_addr, mem_data}, 40'h0);
        else chk("R4 scoreboard write", {mem_addr, mem_data}, expq.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic host_wr(input logic b, input logic [1:0] f, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_buf = b; cfg_fld = f; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic last, input logic crc_ok);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = last; in_crc_ok = crc_ok;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  // driver: expected writes pushed into the scoreboard
  task automatic expect_wr(input logic [31:0] a, input logic [7:0] d);
    expq.push_back({a, d});
  endtask

  task automatic do_gap(input logic [15:0] g);
    @(negedge clk);
    gap_valid = 1'b1; gap_len = g;
    @(negedge clk);
    gap_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 status_a", 40'(status_a), 40'h0);
    chk("R1 status_b", 40'(status_b), 40'h0);
    chk("R1 next_buf/busy", {38'h0, next_buf, rx_busy}, 40'h0);
    chk("R1 cur_addr", 40'(cur_addr), 40'h0);
    chk("R1 mem_valid/in_ready", {38'h0, mem_valid, in_ready}, 40'h1);
    rst_n = 1'b1;

    // program: A 0x1000 limit 8, B 0x2000 limit 4
    host_wr(1'b0, 2'd0, 32'h1000); host_wr(1'b0, 2'd1, 32'd8); host_wr(1'b0, 2'd2, 32'h80);
    host_wr(1'b1, 2'd0, 32'h2000); host_wr(1'b1, 2'd1, 32'd4); host_wr(1'b1, 2'd2, 32'h80);
    chk("R2 status_a written", 40'(status_a), 40'h80);
    chk("R2 status_b written", 40'(status_b), 40'h80);

    // frame 1: five bytes into A, CRC good
    for (int i = 0; i < 5; i++) expect_wr(32'h1000 + 32'(i), 8'h10 + 8'(i));
    send_byte(8'h10, 1'b0, 1'b1);
    chk("R3 busy after first byte", 40'(rx_busy), 40'h1);
    chk("R3 next_buf flipped to B", 40'(next_buf), 40'h1);
    for (int i = 1; i < 5; i++) send_byte(8'h10 + 8'(i), i == 4, 1'b1);
    drain();
    chk("R6 status_a closed", 40'(status_a), 40'h01);
    chk("R6 frame_len", 40'(frame_len), 40'd5);
    chk("R6 busy cleared", 40'(rx_busy), 40'h0);
    chk("R4 cur_addr after frame", 40'(cur_addr), 40'h1005);

    // frame 2: six bytes into B (limit 4), CRC bad
    for (int i = 0; i < 4; i++) expect_wr(32'h2000 + 32'(i), 8'h20 + 8'(i));
    for (int i = 0; i < 6; i++) send_byte(8'h20 + 8'(i), i == 5, 1'b0);
    drain();
    chk("R7 status_b done|crc|trunc", 40'(status_b), 40'h07);
    chk("R7 frame_len equals limit", 40'(frame_len), 40'd4);
    chk("R6 next_buf back to A", 40'(next_buf), 40'h0);

    // frame 3: A not owned -> dropped with overrun
    begin
      int w0;
      w0 = writes;
      for (int i = 0; i < 3; i++) send_byte(8'h30 + 8'(i), i == 2, 1'b1);
      repeat (4) @(negedge clk);
      chk("R5 no writes", 40'(writes - w0), 40'h0);
      chk("R5 status_a overrun", 40'(status_a), 40'h09);
      chk("R5 next_buf unchanged/busy low", {38'h0, next_buf, rx_busy}, 40'h0);
    end

    // frame 4: gaps, A 0x3000 limit 10, B 0x4000 limit 6
    host_wr(1'b0, 2'd0, 32'h3000); host_wr(1'b0, 2'd1, 32'd10); host_wr(1'b0, 2'd2, 32'h80);
    host_wr(1'b1, 2'd0, 32'h4000); host_wr(1'b1, 2'd1, 32'd6); host_wr(1'b1, 2'd2, 32'h80);
    expect_wr(32'h3000, 8'h40); expect_wr(32'h3001, 8'h41);
    expect_wr(32'h3005, 8'h42); expect_wr(32'h4003, 8'h43);
    send_byte(8'h40, 1'b0, 1'b1);
    send_byte(8'h41, 1'b0, 1'b1);
    do_gap(16'd3);
    chk("R9 cur_addr after small gap", 40'(cur_addr), 40'h3005);
    send_byte(8'h42, 1'b0, 1'b1);
    do_gap(16'd7);
    chk("R10 cur_addr in other buffer", 40'(cur_addr), 40'h4003);
    chk("R10 status_a closed", 40'(status_a), 40'h01);
    chk("R10 next_buf flipped", 40'(next_buf), 40'h0);
    chk("R10 still busy", 40'(rx_busy), 40'h1);
    send_byte(8'h43, 1'b1, 1'b1);
    drain();
    chk("R6 status_b closed", 40'(status_b), 40'h01);
    chk("R6 frame_len after switch", 40'(frame_len), 40'd4);

    // frame 5: exactly at limit, A 0x5000 limit 3
    host_wr(1'b0, 2'd0, 32'h5000); host_wr(1'b0, 2'd1, 32'd3); host_wr(1'b0, 2'd2, 32'h80);
    for (int i = 0; i < 3; i++) expect_wr(32'h5000 + 32'(i), 8'h50 + 8'(i));
    for (int i = 0; i < 3; i++) send_byte(8'h50 + 8'(i), i == 2, 1'b1);
    drain();
    chk("R11 status_a not truncated", 40'(status_a), 40'h01);
    chk("R11 frame_len equals limit", 40'(frame_len), 40'd3);
    chk("R4 scoreboard empty", 40'(expq.size()), 40'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule